// File: doc/BRIEF.md
# Dual-Port Configurable GPIO Controller

This block controls two 8-bit general-purpose I/O ports, called port A and port B. A small register bus holds the output latch and a two-bit drive mode for every pin. Port A also has an analog-select register. The block turns each pin's mode and latch into three pad controls: output value, output enable and pull-up enable. A read of either port register returns the pad levels, with masking applied, and never the latch contents.

Software picks the mode of pin `k` by writing bit `k` of a high-bit register and bit `k` of a low-bit register. To use a port A pin as an analog input, software selects input-only mode and also sets the pin's analog-select bit. The block applies these two settings independently of each other.

Some port B pins have fixed limits. Pin 5 can only receive, whatever its mode code. Pins 2 and 3 can only be input-only or open-drain, so any other code written for them acts as open-drain. The registers keep the raw code that was written, and the limit is applied when the mode is decoded.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every mode high bit is 1 and every mode low bit is 0, so every pin is input-only. Both latches are 8'hFF and analog-select is 0. Every pad output enable and pull-up enable is 0.
- R2: A write at a bus address takes effect at the clock edge where `bus_we` is sampled high. The registers read back as follows: address 2 is the port A high bits, 3 the port A low bits, 4 the port B high bits, 5 the port B low bits and 6 analog-select.
- R3: Mode code {high,low} decodes as follows. 00 is quasi-bidirectional: pull-up on, output enable = NOT latch. 01 is push-pull: output enable = 1. 10 is input-only: output enable and pull-up both off. 11 is open-drain: output enable = NOT latch, pull-up off. The output value always equals the pin's latch bit.
- R4: Writes to address 0 set the port A latch and writes to address 1 set the port B latch. Reads of these addresses return the pad inputs, never the latch.
- R5: Analog-select bits 1 to 5 force the matching bits of a port A read (address 0) to 0 whatever the pad level. Bits 0, 6 and 7 are discarded: they read back as 0 and mask nothing.
- R6: Analog-select has no effect on pad drive controls. Input-only mode on its own does not mask reads.
- R7: Port B pin 5 has output enable 0 and pull-up 0 under every mode code.
- R8: Port B pins 2 and 3 behave as input-only for code 10 and as open-drain for every other code.
- R9: Reads of addresses 7 to 15 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 8 | Combinational read data |
| pa_in | input | 8 | Port A pad levels |
| pa_out | output | 8 | Port A output value |
| pa_oe | output | 8 | Port A output enable |
| pa_pu | output | 8 | Port A pull-up enable |
| pb_in | input | 8 | Port B pad levels |
| pb_out | output | 8 | Port B output value |
| pb_oe | output | 8 | Port B output enable |
| pb_pu | output | 8 | Port B pull-up enable |

## Verification
Register writes, and the pad controls derived from them, are due right after the rising edge that samples the strobe, so they have zero cycles of latency after that edge. Port reads follow pad input or address changes in the same cycle, with no clock in between. The bench changes every input on the falling edge and then waits a short settle time before comparing all outputs with a behavioural model. The model itself updates only on rising edges, so each comparison sees exactly one edge's worth of register change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    PM_QUASI = 2'b00,
    PM_PUSH  = 2'b01,
    PM_INPUT = 2'b10,
    PM_OPEN  = 2'b11
  } pin_mode_e;

  localparam logic [ADDR_W-1:0] A_PORT_A  = 4'd0;
  localparam logic [ADDR_W-1:0] A_PORT_B  = 4'd1;
  localparam logic [ADDR_W-1:0] A_A_HI    = 4'd2;
  localparam logic [ADDR_W-1:0] A_A_LO    = 4'd3;
  localparam logic [ADDR_W-1:0] A_B_HI    = 4'd4;
  localparam logic [ADDR_W-1:0] A_B_LO    = 4'd5;
  localparam logic [ADDR_W-1:0] A_ANA_SEL = 4'd6;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
#(
  parameter int               PIN_W    = 8,
  parameter logic [PIN_W-1:0] ANA_MASK = 8'h3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  wdata,
  input  logic              we,
  output logic [PIN_W-1:0]  lat_a,
  output logic [PIN_W-1:0]  lat_b,
  output logic [PIN_W-1:0]  hi_a,
  output logic [PIN_W-1:0]  lo_a,
  output logic [PIN_W-1:0]  hi_b,
  output logic [PIN_W-1:0]  lo_b,
  output logic [PIN_W-1:0]  ana
);
  localparam logic [PIN_W-1:0] ALL_ONE  = {PIN_W{1'b1}};
  localparam logic [PIN_W-1:0] ALL_ZERO = {PIN_W{1'b0}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a <= ALL_ONE;
      lat_b <= ALL_ONE;
      hi_a  <= ALL_ONE;
      lo_a  <= ALL_ZERO;
      hi_b  <= ALL_ONE;
      lo_b  <= ALL_ZERO;
      ana   <= ALL_ZERO;
    end else if (we) begin
      case (addr)
        A_PORT_A:  lat_a <= wdata;
        A_PORT_B:  lat_b <= wdata;
        A_A_HI:    hi_a  <= wdata;
        A_A_LO:    lo_a  <= wdata;
        A_B_HI:    hi_b  <= wdata;
        A_B_LO:    lo_b  <= wdata;
        A_ANA_SEL: ana   <= wdata & ANA_MASK;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_pkg::*;
#(
  parameter int               PIN_W         = 8,
  parameter logic [PIN_W-1:0] FORCE_IN_MASK = '0,
  parameter logic [PIN_W-1:0] OD_ONLY_MASK  = '0
) (
  input  logic [PIN_W-1:0] lat,
  input  logic [PIN_W-1:0] hi,
  input  logic [PIN_W-1:0] lo,
  output logic [PIN_W-1:0] out_o,
  output logic [PIN_W-1:0] oe_o,
  output logic [PIN_W-1:0] pu_o
);
  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    pin_mode_e raw_mode;
    pin_mode_e eff_mode;
    logic      oe_b;
    logic      pu_b;

    always_comb begin
      raw_mode = pin_mode_e'({hi[i], lo[i]});
      if (FORCE_IN_MASK[i])
        eff_mode = PM_INPUT;
      else if (OD_ONLY_MASK[i] && raw_mode != PM_INPUT)
        eff_mode = PM_OPEN;
      else
        eff_mode = raw_mode;

      oe_b = 1'b0;
      pu_b = 1'b0;
      unique case (eff_mode)
        PM_QUASI: begin
          pu_b = 1'b1;
          oe_b = ~lat[i];
        end
        PM_PUSH:  oe_b = 1'b1;
        PM_INPUT: oe_b = 1'b0;
        PM_OPEN:  oe_b = ~lat[i];
      endcase
    end

    assign out_o[i] = lat[i];
    assign oe_o[i]  = oe_b;
    assign pu_o[i]  = pu_b;
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  pad_a,
  input  logic [PIN_W-1:0]  pad_b,
  input  logic [PIN_W-1:0]  hi_a,
  input  logic [PIN_W-1:0]  lo_a,
  input  logic [PIN_W-1:0]  hi_b,
  input  logic [PIN_W-1:0]  lo_b,
  input  logic [PIN_W-1:0]  ana,
  output logic [PIN_W-1:0]  rdata
);
  always_comb begin
    unique case (addr)
      A_PORT_A:  rdata = pad_a & ~ana;
      A_PORT_B:  rdata = pad_b;
      A_A_HI:    rdata = hi_a;
      A_A_LO:    rdata = lo_a;
      A_B_HI:    rdata = hi_b;
      A_B_LO:    rdata = lo_b;
      A_ANA_SEL: rdata = ana;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int               PIN_W      = 8,
  parameter logic [PIN_W-1:0] ANA_MASK   = 8'h3E,
  parameter logic [PIN_W-1:0] B_IN_ONLY  = 8'h20,
  parameter logic [PIN_W-1:0] B_OD_ONLY  = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PIN_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pa_in,
  output logic [PIN_W-1:0]  pa_out,
  output logic [PIN_W-1:0]  pa_oe,
  output logic [PIN_W-1:0]  pa_pu,
  input  logic [PIN_W-1:0]  pb_in,
  output logic [PIN_W-1:0]  pb_out,
  output logic [PIN_W-1:0]  pb_oe,
  output logic [PIN_W-1:0]  pb_pu
);
  logic [PIN_W-1:0] lat_a_q, lat_b_q;
  logic [PIN_W-1:0] hi_a_q, lo_a_q, hi_b_q, lo_b_q;
  logic [PIN_W-1:0] ana_q;

  gpio_cfg_regs #(.PIN_W(PIN_W), .ANA_MASK(ANA_MASK)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .we    (bus_we),
    .lat_a (lat_a_q),
    .lat_b (lat_b_q),
    .hi_a  (hi_a_q),
    .lo_a  (lo_a_q),
    .hi_b  (hi_b_q),
    .lo_b  (lo_b_q),
    .ana   (ana_q)
  );

  gpio_pin_drive #(
    .PIN_W(PIN_W), .FORCE_IN_MASK('0), .OD_ONLY_MASK('0)
  ) u_drive_a (
    .lat   (lat_a_q),
    .hi    (hi_a_q),
    .lo    (lo_a_q),
    .out_o (pa_out),
    .oe_o  (pa_oe),
    .pu_o  (pa_pu)
  );

  gpio_pin_drive #(
    .PIN_W(PIN_W), .FORCE_IN_MASK(B_IN_ONLY), .OD_ONLY_MASK(B_OD_ONLY)
  ) u_drive_b (
    .lat   (lat_b_q),
    .hi    (hi_b_q),
    .lo    (lo_b_q),
    .out_o (pb_out),
    .oe_o  (pb_oe),
    .pu_o  (pb_pu)
  );

  gpio_read_mux #(.PIN_W(PIN_W)) u_rmux (
    .addr  (bus_addr),
    .pad_a (pa_in),
    .pad_b (pb_in),
    .hi_a  (hi_a_q),
    .lo_a  (lo_a_q),
    .hi_b  (hi_b_q),
    .lo_b  (lo_b_q),
    .ana   (ana_q),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PIN_W-1:0]  bus_wdata,
  input logic              bus_we,
  input logic [PIN_W-1:0]  bus_rdata,
  input logic [PIN_W-1:0]  pa_out,
  input logic [PIN_W-1:0]  pa_oe,
  input logic [PIN_W-1:0]  pa_pu,
  input logic [PIN_W-1:0]  pb_out,
  input logic [PIN_W-1:0]  pb_oe,
  input logic [PIN_W-1:0]  pb_pu,
  input logic [PIN_W-1:0]  ana_q,
  input logic [PIN_W-1:0]  hi_a_q
);
  // R1: a cycle spent in reset leaves every driver and pull-up off
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (pa_oe == '0 && pb_oe == '0 && pa_pu == '0 && pb_pu == '0));

  // R2: a mode write lands on the sampling edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_A_HI) |=> (hi_a_q == $past(bus_wdata)));

  // R3: a pulled-up pin is quasi-bidirectional, so it drives only a low level
  p_quasi_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pa_pu & ~(pa_oe ^ pa_out)) == '0) && ((pb_pu & ~(pb_oe ^ pb_out)) == '0));

  // R5: a selected analog pin never reads back as 1
  p_ana_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_PORT_A) |-> ((bus_rdata & ana_q) == '0));

  // R7: the receive-only pin never drives and never pulls up
  p_pin5_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_oe[5] == 1'b0 && pb_pu[5] == 1'b0));

  // R8: restricted pins only ever sink, never pull up
  p_od_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pb_oe[2] -> !pb_out[2]) && (pb_oe[3] -> !pb_out[3]) && !pb_pu[2] && !pb_pu[3]));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.PIN_W(PIN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .pa_out    (pa_out),
  .pa_oe     (pa_oe),
  .pa_pu     (pa_pu),
  .pb_out    (pb_out),
  .pb_oe     (pb_oe),
  .pb_pu     (pb_pu),
  .ana_q     (ana_q),
  .hi_a_q    (hi_a_q)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] pa_in = '0;
  logic [7:0] pb_in = '0;
  logic [7:0] rdata, pa_out, pa_oe, pa_pu, pb_out, pb_oe, pb_pu;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_pu(pa_pu),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_pu(pb_pu)
  );

  // reference model state
  logic [7:0] m_lat_a, m_lat_b, m_hi_a, m_lo_a, m_hi_b, m_lo_b, m_ana;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat_a = 8'hFF; m_lat_b = 8'hFF;
      m_hi_a = 8'hFF; m_lo_a = 8'h00; m_hi_b = 8'hFF; m_lo_b = 8'h00;
      m_ana = 8'h00;
    end else if (we) begin
      case (addr)
        0: m_lat_a = wdata;
        1: m_lat_b = wdata;
        2: m_hi_a = wdata;
        3: m_lo_a = wdata;
        4: m_hi_b = wdata;
        5: m_lo_b = wdata;
        6: m_ana = wdata & 8'h3E;
        default: ;
      endcase
    end
  end

  function automatic void model_port(input int port, output logic [7:0] o,
                                     output logic [7:0] e, output logic [7:0] p);
    for (int k = 0; k < 8; k++) begin
      int m;
      bit l;
      l = (port == 0) ? m_lat_a[k] : m_lat_b[k];
      m = (port == 0) ? 2 * m_hi_a[k] + m_lo_a[k] : 2 * m_hi_b[k] + m_lo_b[k];
      if (port == 1 && k == 5) m = 2;
      if (port == 1 && (k == 2 || k == 3) && m != 2) m = 3;
      o[k] = l;
      e[k] = (m == 1) || ((m == 0 || m == 3) && !l);
      p[k] = (m == 0);
    end
  endfunction

  function automatic logic [7:0] model_rd();
    case (addr)
      0: return pa_in & ~m_ana;
      1: return pb_in;
      2: return m_hi_a;
      3: return m_lo_a;
      4: return m_hi_b;
      5: return m_lo_b;
      6: return m_ana;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] eo, ee, ep;
    string rtag;
    case (addr)
      0: rtag = (m_ana != 0) ? "R5" : "R4";
      1: rtag = "R4";
      2, 3, 4, 5, 6: rtag = "R2";
      default: rtag = "R9";
    endcase
    chk(rtag, "bus_rdata", rdata, model_rd());
    model_port(0, eo, ee, ep);
    chk("R3", "pa_out", pa_out, eo);
    chk("R3", "pa_oe", pa_oe, ee);
    chk("R3", "pa_pu", pa_pu, ep);
    model_port(1, eo, ee, ep);
    chk("R3", "pb_out", pb_out, eo);
    chk("R3", "pb_oe other", pb_oe & 8'hD3, ee & 8'hD3);
    chk("R3", "pb_pu other", pb_pu & 8'hD3, ep & 8'hD3);
    chk("R7", "pb_oe/pu pin5", {pb_oe[5], pb_pu[5]}, {ee[5], ep[5]});
    chk("R8", "pb_oe pins2-3", pb_oe & 8'h0C, ee & 8'h0C);
    chk("R8", "pb_pu pins2-3", pb_pu & 8'h0C, ep & 8'h0C);
  endtask

  task automatic step(input logic [3:0] a, input logic [7:0] d, input logic w,
                      input logic [7:0] ia, input logic [7:0] ib);
    @(negedge clk);
    addr = a; wdata = d; we = w; pa_in = ia; pb_in = ib;
    #2;
    compare_all();
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(a, d, 1'b1, pa_in, pb_in);
  endtask

  task automatic rd(input logic [3:0] a);
    step(a, 8'h00, 1'b0, pa_in, pb_in);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: state during and after reset
    repeat (2) step(4'd2, 8'h00, 1'b0, 8'hA5, 8'h5A);
    @(negedge clk); rst_n = 1'b1;
    rd(4'd2); chk("R1", "hi_a after reset", rdata, 8'hFF);
    rd(4'd5); chk("R1", "lo_b after reset", rdata, 8'h00);
    chk("R1", "pa_oe after reset", pa_oe, 8'h00);
    chk("R1", "pb_pu after reset", pb_pu, 8'h00);
    rd(4'd6); chk("R1", "ana after reset", rdata, 8'h00);

    // R4: latch write does not show on port reads
    wr(4'd0, 8'h5A); rd(4'd0);
    step(4'd0, 8'h00, 1'b0, 8'h3C, 8'hC3);
    chk("R4", "port A read is pads", rdata, 8'h3C);

    // R3: every mode across port A and port B
    for (int md = 0; md < 4; md++) begin
      wr(4'd2, (md & 2) ? 8'hFF : 8'h00);
      wr(4'd3, (md & 1) ? 8'hFF : 8'h00);
      wr(4'd4, (md & 2) ? 8'hFF : 8'h00);
      wr(4'd5, (md & 1) ? 8'hFF : 8'h00);
      wr(4'd1, 8'h96);
      rd(4'd1);
    end

    // R6: analog select leaves drive alone while pins push-pull
    wr(4'd2, 8'h00); wr(4'd3, 8'hFF); wr(4'd6, 8'hFF);
    step(4'd0, 8'h00, 1'b0, 8'hFF, 8'hFF);
    chk("R6", "pa_oe with analog select", pa_oe, 8'hFF);
    chk("R5", "masked port A read", rdata, 8'hC1);
    rd(4'd6); chk("R5", "ana readback drops 0/6/7", rdata, 8'h3E);
    // R6: input-only mode alone does not mask reads
    wr(4'd2, 8'hFF); wr(4'd3, 8'h00); wr(4'd6, 8'h00);
    step(4'd0, 8'h00, 1'b0, 8'hFF, 8'h00);
    chk("R6", "input-only read unmasked", rdata, 8'hFF);
    wr(4'd6, 8'hC1);
    step(4'd0, 8'h00, 1'b0, 8'hFF, 8'h00);
    chk("R5", "unmapped ana bits mask nothing", rdata, 8'hFF);

    // R8: restricted pins under each raw code with latch low
    wr(4'd1, 8'h00);
    for (int md = 0; md < 4; md++) begin
      wr(4'd4, (md & 2) ? 8'h0C : 8'h00);
      wr(4'd5, (md & 1) ? 8'h0C : 8'h00);
      rd(4'd4);
      chk("R8", "pins2-3 oe", pb_oe & 8'h0C, (md == 2) ? 8'h00 : 8'h0C);
    end

    // R9: unmapped addresses
    wr(4'd9, 8'h00); wr(4'd15, 8'h00);
    rd(4'd2); chk("R9", "hi_a unchanged by unmapped writes", rdata, 8'hFF);
    rd(4'd12);

    // mixed traffic
    for (int i = 0; i < 400; i++)
      step(4'($urandom_range(0, 15)), 8'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule